// File: doc/BRIEF.md
# Codec Clock and Frame Generator

This block supplies the timing for a serial audio codec port. A master clock for the codec is always produced by dividing the system clock. When generate mode is selected, the block also derives a bit clock from the master clock and a frame sync from the bit clock, and drives both onto the bidirectional codec pins with their output enables asserted. When generate mode is off, the pins are released and the bit clock and frame sync coming from an external codec are synchronised into the system clock domain and handed to the serial logic instead.

Every stage is a counter on the system clock, advanced by a clock-enable strobe from the stage before it. Each output is a flop, so no derived clock drives any internal flop. Divider values are static inputs. A new value is latched only when its divider reaches terminal count, so the period in progress always completes. The frame sync is one bit clock wide and has programmable polarity. The internal frame seen by the serial logic is always active high.

Top module: `codec_clkgen`

## Requirements
- R1: While rst_ni is low, mclk_o and bclk_o are 0 and frame_o sits at its inactive level. On the first clk_i edge after release, mclk_o, bclk_o and the frame go active together.
- R2: mclk_o has a period of M+1 clk_i cycles and is high for ceil((M+1)/2) of them, where M is mclk_div_i.
- R3: In generate mode, bclk_o has a period of B+1 master clock periods and is high for ceil((B+1)/2) of them, where B is bclk_div_i. Every edge of bclk_o coincides with a rising edge of mclk_o.
- R4: In generate mode, the frame is active for exactly one bit clock period once every F+1 bit clock periods, where F is frame_div_i. The frame changes only in cycles where the bit clock rises.
- R5: frame_o is active high when sync_pol_i is 1 and active low when it is 0. sel_frame_o is active high in both cases.
- R6: When gen_mode_i is 1, bclk_oe_o and frame_oe_o are 1. When it is 0, both enables are 0 and bclk_o and frame_o are driven 0.
- R7: When gen_mode_i is 0, sel_bclk_o equals ext_bclk_i delayed by two clk_i cycles. sel_frame_o equals ext_frame_i delayed by two cycles, inverted when sync_pol_i is 0.
- R8: mclk_o keeps running with the R2 timing when gen_mode_i is 0.
- R9: A divider value of 0 on any of the three dividers behaves as a value of 1.
- R10: A change of a divider value takes effect at that divider's next terminal count. The period in progress completes with the old value, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gen_mode_i | input | 1 | 1: generate bit clock and frame; 0: take them from the external codec |
| sync_pol_i | input | 1 | Frame polarity, 1 active high |
| mclk_div_i | input | 9 | Master clock divider value M |
| bclk_div_i | input | 16 | Bit clock divider value B |
| frame_div_i | input | 8 | Frame divider value F |
| ext_bclk_i | input | 1 | Bit clock from the external codec |
| ext_frame_i | input | 1 | Frame sync from the external codec |
| mclk_o | output | 1 | Master clock to the codec |
| bclk_o | output | 1 | Bit clock pad output |
| bclk_oe_o | output | 1 | Bit clock pad output enable |
| frame_o | output | 1 | Frame sync pad output |
| frame_oe_o | output | 1 | Frame sync pad output enable |
| sel_bclk_o | output | 1 | Selected bit clock level for the serial logic |
| sel_frame_o | output | 1 | Selected frame, active high, for the serial logic |

## Verification
Two events can land in the same system clock cycle. One is a divider reaching terminal count and reloading its value. The other is a new divider value arriving just after the bit clock edge that began the current period. The bench provokes this by changing bclk_div_i right after it sees a bit clock rise. It then measures the remaining high and low phases, which must keep the old lengths, and the next full period, which must have the new length. The second coincidence is the frame toggling in the same cycle as the bit clock and master clock rise. The measured frame width and period, taken in system cycles across several divider sets, show that the edges line up, and bound properties check it on every edge.

// File: rtl/codec_clk_pkg.sv
package codec_clk_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    DIV_SQUARE = 1'b0,
    DIV_PULSE  = 1'b1
  } div_shape_e;
endpackage

// File: rtl/codec_clk_div.sv
module codec_clk_div #(
  parameter int W = 9,
  parameter codec_clk_pkg::div_shape_e SHAPE = codec_clk_pkg::DIV_SQUARE
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o,
  output logic         clk_o
);
  logic [W-1:0] cnt_q, cnt_d, lim_q, lim_d, div_eff;
  logic         wrap, out_d, out_q;

  assign div_eff = (div_i == '0) ? W'(1) : div_i;
  assign wrap    = en_i && (cnt_q == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (wrap) begin
      cnt_d = '0;
      lim_d = div_eff;   // new ratio only at terminal count
    end else if (en_i) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  generate
    if (SHAPE == codec_clk_pkg::DIV_PULSE) begin : g_pulse
      assign out_d = (cnt_d == '0);
    end else begin : g_square
      logic [W:0] half;
      assign half  = ({1'b0, lim_d} + (W+1)'(2)) >> 1;
      assign out_d = ({1'b0, cnt_d} < half);
    end
  endgenerate

  // lim_q resets to 0 so the first enable wraps and loads div_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      out_q <= out_d;
    end
  end

  assign tick_o = wrap;
  assign clk_o  = out_q;
endmodule

// File: rtl/codec_sync.sv
module codec_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/codec_clkgen.sv
module codec_clkgen #(
  parameter int MDIV_W = 9,
  parameter int BDIV_W = 16,
  parameter int FDIV_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gen_mode_i,
  input  logic              sync_pol_i,
  input  logic [MDIV_W-1:0] mclk_div_i,
  input  logic [BDIV_W-1:0] bclk_div_i,
  input  logic [FDIV_W-1:0] frame_div_i,
  input  logic              ext_bclk_i,
  input  logic              ext_frame_i,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              bclk_oe_o,
  output logic              frame_o,
  output logic              frame_oe_o,
  output logic              sel_bclk_o,
  output logic              sel_frame_o
);
  import codec_clk_pkg::*;

  logic mclk_tick, mclk_q;
  logic bclk_tick, bclk_q;
  logic frame_tick, frame_q;
  logic ext_bclk_s, ext_frame_s, ext_frame_act;

  codec_clk_div #(.W(MDIV_W), .SHAPE(DIV_SQUARE)) u_mclk_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(1'b1),
    .div_i (mclk_div_i), .tick_o(mclk_tick), .clk_o(mclk_q)
  );

  codec_clk_div #(.W(BDIV_W), .SHAPE(DIV_SQUARE)) u_bclk_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(mclk_tick),
    .div_i (bclk_div_i), .tick_o(bclk_tick), .clk_o(bclk_q)
  );

  codec_clk_div #(.W(FDIV_W), .SHAPE(DIV_PULSE)) u_frame_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(bclk_tick),
    .div_i (frame_div_i), .tick_o(frame_tick), .clk_o(frame_q)
  );

  codec_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_bclk_i), .q_o(ext_bclk_s)
  );

  codec_sync #(.STAGES(SYNC_STAGES)) u_sync_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_frame_i), .q_o(ext_frame_s)
  );

  assign ext_frame_act = sync_pol_i ? ext_frame_s : ~ext_frame_s;

  assign mclk_o      = mclk_q;
  assign bclk_oe_o   = gen_mode_i;
  assign frame_oe_o  = gen_mode_i;
  assign bclk_o      = gen_mode_i & bclk_q;
  assign frame_o     = gen_mode_i & (sync_pol_i ? frame_q : ~frame_q);
  assign sel_bclk_o  = gen_mode_i ? bclk_q  : ext_bclk_s;
  assign sel_frame_o = gen_mode_i ? frame_q : ext_frame_act;
endmodule

// File: rtl/codec_clkgen_chk.sv
module codec_clkgen_chk #(
  parameter int MDIV_W = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic gen_mode_i,
  input logic ext_bclk_i,
  input logic mclk_o,
  input logic bclk_o,
  input logic bclk_oe_o,
  input logic frame_o,
  input logic sel_bclk_o,
  input logic sel_frame_o,
  input logic frame_tick
);
  localparam int MAX_RUN = 2 ** (MDIV_W - 1);

  logic [MDIV_W:0] run_q, run_now;
  logic            mclk_prev_q;
  logic [1:0]      since_rst_q;

  assign run_now = (mclk_o != mclk_prev_q) ? (MDIV_W+1)'(1) :
                   ((&run_q) ? run_q : run_q + (MDIV_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= '0;
      mclk_prev_q <= 1'b0;
      since_rst_q <= '0;
    end else begin
      run_q       <= run_now;
      mclk_prev_q <= mclk_o;
      if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end
  end

  assert_mclk_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(run_now) <= MAX_RUN);

  assert_bclk_on_mclk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_mode_i && $past(gen_mode_i) && (bclk_o != $past(bclk_o)))
      |-> (mclk_o && !$past(mclk_o)));

  assert_frame_on_bclk_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_mode_i && $past(gen_mode_i) && (sel_frame_o != $past(sel_frame_o)))
      |-> (sel_bclk_o && !$past(sel_bclk_o)));

  assert_frame_after_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_tick && gen_mode_i) |=> (sel_frame_o || !gen_mode_i));

  assert_pad_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_oe_o |-> (!bclk_o && !frame_o));

  assert_ext_bclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q >= 2'd2 && !gen_mode_i) |-> (sel_bclk_o == $past(ext_bclk_i, 2)));
endmodule

bind codec_clkgen codec_clkgen_chk #(.MDIV_W(MDIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gen_mode_i (gen_mode_i),
  .ext_bclk_i (ext_bclk_i),
  .mclk_o     (mclk_o),
  .bclk_o     (bclk_o),
  .bclk_oe_o  (bclk_oe_o),
  .frame_o    (frame_o),
  .sel_bclk_o (sel_bclk_o),
  .sel_frame_o(sel_frame_o),
  .frame_tick (frame_tick)
);

// File: tb/tb_codec_clkgen.sv
`timescale 1ns/1ps
module tb_codec_clkgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_mode = 1'b1;
  logic        sync_pol = 1'b1;
  logic [8:0]  mdiv = 9'd1;
  logic [15:0] bdiv = 16'd1;
  logic [7:0]  fdiv = 8'd3;
  logic        ext_bclk = 1'b0;
  logic        ext_frame = 1'b0;
  logic        mclk, bclk, bclk_oe, frame, frame_oe, sel_bclk, sel_frame;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  codec_clkgen dut (
    .clk_i(clk), .rst_ni(rst_n), .gen_mode_i(gen_mode), .sync_pol_i(sync_pol),
    .mclk_div_i(mdiv), .bclk_div_i(bdiv), .frame_div_i(fdiv),
    .ext_bclk_i(ext_bclk), .ext_frame_i(ext_frame),
    .mclk_o(mclk), .bclk_o(bclk), .bclk_oe_o(bclk_oe),
    .frame_o(frame), .frame_oe_o(frame_oe),
    .sel_bclk_o(sel_bclk), .sel_frame_o(sel_frame)
  );

  typedef struct packed {
    logic [8:0]  m;
    logic [15:0] b;
    logic [7:0]  f;
    logic [15:0] m_per, m_hi, b_per, b_hi, f_per, f_hi;
  } vec_t;

  // expected periods and high times in clk cycles
  localparam vec_t VECS [5] = '{
    '{9'd1,   16'd1, 8'd3, 16'd2,   16'd1,   16'd4,    16'd2,   16'd16,   16'd4},
    '{9'd2,   16'd3, 8'd1, 16'd3,   16'd2,   16'd12,   16'd6,   16'd24,   16'd12},
    '{9'd0,   16'd0, 8'd0, 16'd2,   16'd1,   16'd4,    16'd2,   16'd8,    16'd4},
    '{9'd4,   16'd2, 8'd2, 16'd5,   16'd3,   16'd15,   16'd10,  16'd45,   16'd15},
    '{9'd511, 16'd1, 8'd1, 16'd512, 16'd256, 16'd1024, 16'd512, 16'd2048, 16'd1024}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0:       return mclk;
      1:       return bclk;
      2:       return frame;
      3:       return ~frame;
      default: return sel_frame;
    endcase
  endfunction

  task automatic measure(input int sel, output int hi, output int per);
    while (sig(sel) == 1'b1) @(negedge clk);
    while (sig(sel) == 1'b0) @(negedge clk);
    hi = 0;
    while (sig(sel) == 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (sig(sel) == 1'b0) begin per++; @(negedge clk); end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8ns * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int hi, per, h2, l2;

    // R1 reset state and aligned start
    repeat (2) @(negedge clk);
    chk("R1 mclk in reset", int'(mclk), 0);
    chk("R1 bclk in reset", int'(bclk), 0);
    chk("R1 frame in reset pol1", int'(frame), 0);
    sync_pol = 1'b0;
    @(negedge clk);
    chk("R1 frame in reset pol0", int'(frame), 1);
    sync_pol = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first edge mclk", int'(mclk), 1);
    chk("R1 first edge bclk", int'(bclk), 1);
    chk("R1 first edge frame", int'(frame), 1);

    // R6 enables in generate mode
    chk("R6 bclk_oe gen", int'(bclk_oe), 1);
    chk("R6 frame_oe gen", int'(frame_oe), 1);

    // vector table: R2, R3, R4, R9 (vector 2 holds zero divider values)
    for (int i = 0; i < 5; i++) begin
      mdiv = VECS[i].m;
      bdiv = VECS[i].b;
      fdiv = VECS[i].f;
      do_reset();
      measure(0, hi, per);
      chk(i == 2 ? "R9 mclk period" : "R2 mclk period", per, int'(VECS[i].m_per));
      chk(i == 2 ? "R9 mclk high"   : "R2 mclk high",   hi,  int'(VECS[i].m_hi));
      measure(1, hi, per);
      chk(i == 2 ? "R9 bclk period" : "R3 bclk period", per, int'(VECS[i].b_per));
      chk(i == 2 ? "R9 bclk high"   : "R3 bclk high",   hi,  int'(VECS[i].b_hi));
      measure(2, hi, per);
      chk(i == 2 ? "R9 frame period" : "R4 frame period", per, int'(VECS[i].f_per));
      chk(i == 2 ? "R9 frame width"  : "R4 frame width",  hi,  int'(VECS[i].f_hi));
    end

    // R5 active-low frame on the pad, active-high internal frame
    mdiv = 9'd1; bdiv = 16'd1; fdiv = 8'd3;
    sync_pol = 1'b0;
    do_reset();
    measure(3, hi, per);
    chk("R5 low-active frame width", hi, 4);
    chk("R5 low-active frame period", per, 16);
    measure(4, hi, per);
    chk("R5 sel_frame width", hi, 4);

    // R10 divider change mid-period
    sync_pol = 1'b1;
    do_reset();
    while (bclk == 1'b1) @(negedge clk);
    while (bclk == 1'b0) @(negedge clk);
    bdiv = 16'd3;
    h2 = 0;
    while (bclk == 1'b1) begin h2++; @(negedge clk); end
    l2 = 0;
    while (bclk == 1'b0) begin l2++; @(negedge clk); end
    chk("R10 remaining high keeps old ratio", h2, 2);
    chk("R10 remaining low keeps old ratio", l2, 2);
    hi = 0;
    while (bclk == 1'b1) begin hi++; @(negedge clk); end
    per = hi;
    while (bclk == 1'b0) begin per++; @(negedge clk); end
    chk("R10 new high", hi, 4);
    chk("R10 new period", per, 8);

    // R6 / R7 / R8 input mode
    gen_mode = 1'b0;
    mdiv = 9'd2;
    sync_pol = 1'b1;
    ext_bclk = 1'b0; ext_frame = 1'b0;
    do_reset();
    repeat (3) @(negedge clk);
    chk("R6 bclk_oe input", int'(bclk_oe), 0);
    chk("R6 frame_oe input", int'(frame_oe), 0);
    ext_bclk = 1'b1; ext_frame = 1'b1;
    @(negedge clk);
    chk("R7 bclk latency 1", int'(sel_bclk), 0);
    chk("R6 bclk pad quiet", int'(bclk), 0);
    @(negedge clk);
    chk("R7 bclk after 2", int'(sel_bclk), 1);
    chk("R7 frame pol1 after 2", int'(sel_frame), 1);
    chk("R6 frame pad quiet", int'(frame), 0);
    sync_pol = 1'b0;
    ext_frame = 1'b0;
    ext_bclk = 1'b0;
    @(negedge clk);
    chk("R7 frame pol0 latency 1", int'(sel_frame), 0);
    @(negedge clk);
    chk("R7 frame pol0 after 2", int'(sel_frame), 1);
    chk("R7 bclk low after 2", int'(sel_bclk), 0);
    ext_frame = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 frame pol0 inactive", int'(sel_frame), 0);
    measure(0, hi, per);
    chk("R8 mclk period in input mode", per, 3);
    chk("R8 mclk high in input mode", hi, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule